// File: doc/BRIEF.md
# Root Hub Port Status Controller

This block holds one status word for every downstream port of a USB host root hub; the port count is a parameter with a default of three. Each port delivers single-cycle event pulses: a device arrived, a device left, a remote wakeup was signalled, and a port-suspend command from the register logic. The block turns these into connect, suspend and change flags. It raises a one-cycle status-change interrupt request, or a one-cycle resume-detected request, toward the interrupt logic.

The host controller's two-bit functional state comes in as an input. A wakeup that arrives while the controller is suspended makes the block move the controller to resume by itself. It does this with a write pulse and the new state value. When a device that owns the one outstanding transfer is unplugged, the block asks the transfer engine to cancel that transfer. A controller-wide reset clears every port word and requests a port reset on each port that still has a device attached.

All interfaces are plain control and status pins with no handshake. The block has no back-pressure: every event is taken in the cycle it arrives, and every result appears one clock later. Register bus decoding, software write-to-clear of the change flags and the transfer engine itself are outside this block.

Top module: `rhps_top`

## Requirements
- R1: An attach event sets the connect flag (status bit 0) and the connect-change flag (status bit 2) of its port one cycle later. Each port's status is 4 bits at offset 4*port in `port_stat_o`.
- R2: `rhsc_irq_o` pulses for one cycle, one cycle after an attach or detach event, only if that event altered the port's status word. An event that leaves the word unchanged raises nothing.
- R3: A detach event on a connected port clears the connect flag and sets the connect-change flag. A detach on a port that is not connected leaves the word unchanged.
- R4: A detach on port `xfer_owner_i` while `xfer_pending_i` is high gives a one-cycle `cancel_o` pulse, with `cancel_port_o` equal to that port, one cycle later. A detach on any other port gives no cancel.
- R5: A wakeup on a suspended port sets the suspend-change flag (bit 3) and clears the suspend flag (bit 1). If the controller is not in suspend, this also raises `rhsc_irq_o`.
- R6: The functional-state encoding is reset 00, resume 01, operational 10, suspend 11. A wakeup while the state is 11, whether or not its port is suspended, gives one-cycle pulses on `resume_irq_o` and `fs_wr_o` with `fs_wr_val_o` = 01. That wakeup raises no `rhsc_irq_o`.
- R7: Events on the same cycle are handled in ascending port order. After a lower port's wakeup has moved the controller to resume, a higher port's wakeup of a suspended port in the same cycle raises `rhsc_irq_o`.
- R8: A `ctrl_reset_i` pulse clears every status word, ignores the port events of that cycle, and pulses `port_reset_o` one cycle later for each port whose `dev_present_i` bit is set.
- R9: A port-suspend command sets the suspend flag only on a connected port and raises no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_reset_i | input | 1 | Controller-wide reset pulse |
| fs_i | input | 2 | Current controller functional state |
| attach_i | input | PORTS | Per-port device attach pulse |
| detach_i | input | PORTS | Per-port device detach pulse |
| wakeup_i | input | PORTS | Per-port remote wakeup pulse |
| suspend_cmd_i | input | PORTS | Per-port suspend command pulse |
| dev_present_i | input | PORTS | Per-port device-attached level |
| xfer_pending_i | input | 1 | An asynchronous transfer is outstanding |
| xfer_owner_i | input | IDXW | Port owning the outstanding transfer |
| port_stat_o | output | 4*PORTS | Status words, 4 bits per port |
| rhsc_irq_o | output | 1 | Status-change interrupt request pulse |
| resume_irq_o | output | 1 | Resume-detected interrupt request pulse |
| fs_wr_o | output | 1 | Functional-state write pulse |
| fs_wr_val_o | output | 2 | Functional-state value to write |
| cancel_o | output | 1 | Cancel-transfer request pulse |
| cancel_port_o | output | IDXW | Port whose transfer is cancelled |
| port_reset_o | output | PORTS | Per-port reset request pulse |

## Verification
The tests apply attach and detach events twice in a row. Only the first of each pair changes the status word, so this shows that an interrupt follows a real change and not merely an event. Wakeups are applied with every pairing of port suspended or not and controller suspended or operational. This separates the status-change path from the resume-detected path and from no action at all. A two-port wakeup in the same cycle under controller suspend shows the ascending order, because the higher port must see the resume state left by the lower one. A controller reset given together with an attach shows that reset wins, and it exposes the port-reset pattern that follows device presence.

// File: rtl/rhps_pkg.sv
package rhps_pkg;

  typedef enum logic [1:0] {
    FS_RESET   = 2'b00,
    FS_RESUME  = 2'b01,
    FS_OPER    = 2'b10,
    FS_SUSPEND = 2'b11
  } fstate_e;

  // Packed MSB first: bit3 susp_chg, bit2 conn_chg, bit1 suspended, bit0 connected
  typedef struct packed {
    logic susp_chg;
    logic conn_chg;
    logic suspended;
    logic connected;
  } pstat_t;

  localparam int PSTAT_W = 4;

endpackage

// File: rtl/rhps_port_cell.sv
module rhps_port_cell
  import rhps_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr_i,
  input  logic       ev_attach_i,
  input  logic       ev_detach_i,
  input  logic       ev_wake_i,
  input  logic       ev_susp_i,
  input  logic [1:0] fs_in_i,
  output logic [1:0] fs_out_o,
  output pstat_t     stat_o,
  output logic       rhsc_req_o,
  output logic       rd_req_o
);

  pstat_t cur_q, base, nxt;
  logic   ad_chg, wake_rhsc;

  always_comb begin
    base = cur_q;
    if (ev_susp_i && cur_q.connected) base.suspended = 1'b1;
    nxt = base;
    if (ev_attach_i) begin
      nxt.connected = 1'b1;
      nxt.conn_chg  = 1'b1;
    end
    if (ev_detach_i && nxt.connected) begin
      nxt.connected = 1'b0;
      nxt.conn_chg  = 1'b1;
    end
    ad_chg    = (nxt != base);
    wake_rhsc = 1'b0;
    rd_req_o  = 1'b0;
    fs_out_o  = fs_in_i;
    if (ev_wake_i) begin
      if (nxt.suspended) begin
        nxt.susp_chg  = 1'b1;
        nxt.suspended = 1'b0;
        wake_rhsc     = 1'b1;
      end
      if (fs_in_i == FS_SUSPEND) begin
        fs_out_o  = FS_RESUME;
        rd_req_o  = 1'b1;
        wake_rhsc = 1'b0;
      end
    end
    rhsc_req_o = ad_chg | wake_rhsc;
    if (clr_i) begin
      nxt        = '0;
      rhsc_req_o = 1'b0;
      rd_req_o   = 1'b0;
      fs_out_o   = fs_in_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur_q <= '0;
    else        cur_q <= nxt;
  end

  assign stat_o = cur_q;

  assert_attach_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_attach_i && !ev_detach_i && !clr_i) |=> (stat_o.connected && stat_o.conn_chg));

  assert_detach_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_detach_i && !ev_attach_i && !clr_i) |=> !stat_o.connected);

  assert_wake_resumes_port_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_wake_i && !clr_i && stat_o.suspended) |=> (stat_o.susp_chg && !stat_o.suspended));

  assert_susp_needs_conn_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_susp_i && !ev_wake_i && !clr_i && !stat_o.connected && !ev_attach_i) |=> !stat_o.suspended);

endmodule

// File: rtl/rhps_cancel_unit.sv
module rhps_cancel_unit #(
  parameter int PORTS = 3,
  localparam int IDXW = (PORTS > 1) ? $clog2(PORTS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic [PORTS-1:0] detach_i,
  input  logic             pending_i,
  input  logic [IDXW-1:0]  owner_i,
  output logic             cancel_o,
  output logic [IDXW-1:0]  cancel_port_o
);

  logic hit;

  always_comb begin
    hit = 1'b0;
    for (int p = 0; p < PORTS; p++) begin
      if (detach_i[p] && owner_i == IDXW'(p)) hit = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cancel_o      <= 1'b0;
      cancel_port_o <= '0;
    end else begin
      cancel_o      <= hit && pending_i && !clr_i;
      cancel_port_o <= owner_i;
    end
  end

  assert_cancel_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cancel_o |-> $past(pending_i && (detach_i != '0)));

endmodule

// File: rtl/rhps_irq_merge.sv
module rhps_irq_merge
  import rhps_pkg::*;
#(
  parameter int PORTS = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic [PORTS-1:0] rhsc_vec_i,
  input  logic [PORTS-1:0] rd_vec_i,
  input  logic [1:0]       fs_end_i,
  input  logic [PORTS-1:0] present_i,
  output logic             rhsc_irq_o,
  output logic             resume_irq_o,
  output logic             fs_wr_o,
  output logic [1:0]       fs_wr_val_o,
  output logic [PORTS-1:0] port_reset_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rhsc_irq_o   <= 1'b0;
      resume_irq_o <= 1'b0;
      fs_wr_o      <= 1'b0;
      fs_wr_val_o  <= FS_RESET;
      port_reset_o <= '0;
    end else begin
      rhsc_irq_o   <= |rhsc_vec_i;
      resume_irq_o <= |rd_vec_i;
      fs_wr_o      <= |rd_vec_i;
      fs_wr_val_o  <= fs_end_i;
      port_reset_o <= clr_i ? present_i : '0;
    end
  end

  assert_fs_write_value_R6: assert property (@(posedge clk) disable iff (!rst_n)
    fs_wr_o |-> (fs_wr_val_o == FS_RESUME));

  assert_port_reset_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (port_reset_o != '0) |-> $past(clr_i));

endmodule

// File: rtl/rhps_top.sv
module rhps_top
  import rhps_pkg::*;
#(
  parameter int PORTS = 3,
  localparam int IDXW = (PORTS > 1) ? $clog2(PORTS) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ctrl_reset_i,
  input  logic [1:0]               fs_i,
  input  logic [PORTS-1:0]         attach_i,
  input  logic [PORTS-1:0]         detach_i,
  input  logic [PORTS-1:0]         wakeup_i,
  input  logic [PORTS-1:0]         suspend_cmd_i,
  input  logic [PORTS-1:0]         dev_present_i,
  input  logic                     xfer_pending_i,
  input  logic [IDXW-1:0]          xfer_owner_i,
  output logic [PORTS*PSTAT_W-1:0] port_stat_o,
  output logic                     rhsc_irq_o,
  output logic                     resume_irq_o,
  output logic                     fs_wr_o,
  output logic [1:0]               fs_wr_val_o,
  output logic                     cancel_o,
  output logic [IDXW-1:0]          cancel_port_o,
  output logic [PORTS-1:0]         port_reset_o
);

  logic [1:0]       fs_chain [PORTS+1];
  logic [PORTS-1:0] rhsc_vec, rd_vec;

  assign fs_chain[0] = fs_i;

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    pstat_t st;
    rhps_port_cell u_cell (
      .clk         (clk),
      .rst_n       (rst_n),
      .clr_i       (ctrl_reset_i),
      .ev_attach_i (attach_i[p]),
      .ev_detach_i (detach_i[p]),
      .ev_wake_i   (wakeup_i[p]),
      .ev_susp_i   (suspend_cmd_i[p]),
      .fs_in_i     (fs_chain[p]),
      .fs_out_o    (fs_chain[p+1]),
      .stat_o      (st),
      .rhsc_req_o  (rhsc_vec[p]),
      .rd_req_o    (rd_vec[p])
    );
    assign port_stat_o[p*PSTAT_W +: PSTAT_W] = st;
  end

  rhps_cancel_unit #(.PORTS(PORTS)) u_cancel (
    .clk           (clk),
    .rst_n         (rst_n),
    .clr_i         (ctrl_reset_i),
    .detach_i      (detach_i),
    .pending_i     (xfer_pending_i),
    .owner_i       (xfer_owner_i),
    .cancel_o      (cancel_o),
    .cancel_port_o (cancel_port_o)
  );

  rhps_irq_merge #(.PORTS(PORTS)) u_irq (
    .clk          (clk),
    .rst_n        (rst_n),
    .clr_i        (ctrl_reset_i),
    .rhsc_vec_i   (rhsc_vec),
    .rd_vec_i     (rd_vec),
    .fs_end_i     (fs_chain[PORTS]),
    .present_i    (dev_present_i),
    .rhsc_irq_o   (rhsc_irq_o),
    .resume_irq_o (resume_irq_o),
    .fs_wr_o      (fs_wr_o),
    .fs_wr_val_o  (fs_wr_val_o),
    .port_reset_o (port_reset_o)
  );

  assert_reset_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_reset_i |=> (port_stat_o == '0));

  assert_resume_needs_susp_R6: assert property (@(posedge clk) disable iff (!rst_n)
    resume_irq_o |-> ($past(fs_i) == FS_SUSPEND));

  assert_rhsc_has_event_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rhsc_irq_o |-> $past((attach_i | detach_i | wakeup_i) != '0));

endmodule

// File: tb/rhps_top_tb_top.sv
`timescale 1ns/1ps
module rhps_top_tb_top;
  localparam int N = 3;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctrl_reset = 1'b0;
  logic [1:0] fs = 2'b10;
  logic [N-1:0] att = '0, det = '0, wk = '0, sp = '0, pres = '0;
  logic pend = 1'b0;
  logic [IW-1:0] owner = '0;
  logic [4*N-1:0] stat;
  logic rhsc, rdi, fswr, canc;
  logic [1:0] fsval;
  logic [IW-1:0] cport;
  logic [N-1:0] preset;
  int vectors = 0, errors = 0;

  always #4 clk = ~clk;

  rhps_top #(.PORTS(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .ctrl_reset_i(ctrl_reset), .fs_i(fs),
    .attach_i(att), .detach_i(det), .wakeup_i(wk), .suspend_cmd_i(sp),
    .dev_present_i(pres), .xfer_pending_i(pend), .xfer_owner_i(owner),
    .port_stat_o(stat), .rhsc_irq_o(rhsc), .resume_irq_o(rdi),
    .fs_wr_o(fswr), .fs_wr_val_o(fsval), .cancel_o(canc),
    .cancel_port_o(cport), .port_reset_o(preset)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] pst(input int p);
    return stat[p*4 +: 4];
  endfunction

  task automatic step(input logic [N-1:0] a, d, w, s, input logic cr);
    @(negedge clk);
    att = a; det = d; wk = w; sp = s; ctrl_reset = cr;
    @(negedge clk);
    att = '0; det = '0; wk = '0; sp = '0; ctrl_reset = 1'b0;
  endtask

  task automatic t_reset_state();
    check("R8 reset status", 32'(stat), 0);
    check("R2 reset rhsc", 32'(rhsc), 0);
    check("R4 reset cancel", 32'(canc), 0);
  endtask

  task automatic t_attach();
    step(3'b010, 0, 0, 0, 0);
    check("R1 attach p1 status", 32'(pst(1)), 4'b0101);
    check("R2 attach rhsc", 32'(rhsc), 1);
    step(0, 0, 0, 0, 0);
    check("R2 rhsc one cycle", 32'(rhsc), 0);
    step(3'b010, 0, 0, 0, 0);
    check("R1 reattach status", 32'(pst(1)), 4'b0101);
    check("R2 no change no rhsc", 32'(rhsc), 0);
  endtask

  task automatic t_detach();
    pend = 1'b1; owner = 2'd1;
    step(0, 3'b010, 0, 0, 0);
    check("R3 detach p1 status", 32'(pst(1)), 4'b0100);
    check("R2 detach rhsc", 32'(rhsc), 1);
    check("R4 cancel pulse", 32'(canc), 1);
    check("R4 cancel port", 32'(cport), 1);
    owner = 2'd2;
    step(0, 3'b010, 0, 0, 0);
    check("R3 detach idle status", 32'(pst(1)), 4'b0100);
    check("R2 detach idle rhsc", 32'(rhsc), 0);
    check("R4 other owner no cancel", 32'(canc), 0);
    pend = 1'b0;
  endtask

  task automatic t_ctrl_reset();
    pres = 3'b101;
    step(3'b001, 0, 0, 0, 1);
    check("R8 status cleared", 32'(stat), 0);
    check("R8 port reset mask", 32'(preset), 3'b101);
    check("R8 attach ignored rhsc", 32'(rhsc), 0);
    step(0, 0, 0, 0, 0);
    check("R8 port reset pulse ends", 32'(preset), 0);
  endtask

  task automatic t_suspend_wake_oper();
    fs = 2'b10;
    step(0, 0, 0, 3'b100, 0);
    check("R9 suspend unconnected", 32'(pst(2)), 0);
    step(3'b100, 0, 0, 0, 0);
    step(0, 0, 0, 3'b100, 0);
    check("R9 suspend connected", 32'(pst(2)), 4'b0111);
    check("R9 suspend no rhsc", 32'(rhsc), 0);
    step(0, 0, 3'b100, 0, 0);
    check("R5 wake status", 32'(pst(2)), 4'b1101);
    check("R5 wake rhsc", 32'(rhsc), 1);
    check("R5 wake no resume irq", 32'(rdi), 0);
    check("R5 wake no fs write", 32'(fswr), 0);
  endtask

  task automatic t_wake_ctrl_susp();
    step(0, 0, 0, 0, 1);
    step(3'b001, 0, 0, 0, 0);
    step(0, 0, 0, 3'b001, 0);
    fs = 2'b11;
    step(0, 0, 3'b001, 0, 0);
    check("R6 port status", 32'(pst(0)), 4'b1101);
    check("R6 resume irq", 32'(rdi), 1);
    check("R6 no rhsc", 32'(rhsc), 0);
    check("R6 fs write", 32'(fswr), 1);
    check("R6 fs value", 32'(fsval), 2'b01);
    step(0, 0, 3'b100, 0, 0);
    check("R6 unsusp port resume irq", 32'(rdi), 1);
    check("R6 unsusp port fs write", 32'(fswr), 1);
    check("R6 unsusp port no rhsc", 32'(rhsc), 0);
    fs = 2'b10;
    step(0, 0, 3'b100, 0, 0);
    check("R6 oper unsusp no resume", 32'(rdi), 0);
    check("R6 oper unsusp no write", 32'(fswr), 0);
    check("R5 oper unsusp no rhsc", 32'(rhsc), 0);
  endtask

  task automatic t_order();
    step(0, 0, 0, 0, 1);
    step(3'b011, 0, 0, 0, 0);
    step(0, 0, 0, 3'b011, 0);
    fs = 2'b11;
    step(0, 0, 3'b011, 0, 0);
    check("R7 p0 status", 32'(pst(0)), 4'b1101);
    check("R7 p1 status", 32'(pst(1)), 4'b1101);
    check("R7 resume irq", 32'(rdi), 1);
    check("R7 higher port rhsc", 32'(rhsc), 1);
    check("R7 fs write", 32'(fswr), 1);
    fs = 2'b10;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_attach();
    t_detach();
    t_ctrl_reset();
    t_suspend_wake_oper();
    t_wake_ctrl_susp();
    t_order();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule